// File: doc/BRIEF.md
# Dual-Modulus Swallow Counter Controller

This block sits between an external dual-modulus prescaler and the phase comparator of a frequency synthesizer. Each output pulse of the prescaler arrives as a one-clock strobe on `pre_pulse`. The block runs a main down-counter and a swallow down-counter side by side. It drives `mod_hi`, which tells the prescaler whether to divide by P+1 (low) or by P (high). The result is that one output cycle spans N·P + A periods of the prescaler input.

At the start of a cycle both counters hold their ratio words and `mod_hi` is low. Every prescaler pulse decrements the main counter. It also decrements the swallow counter while that counter is non-zero. When the swallow counter reaches zero, `mod_hi` goes high and the main counter finishes the remaining N − A counts. The pulse that ends the main count raises `fv` for one clock. The same pulse drops `mod_hi` and presets both counters from the ratio words as they stand at that edge. `fv` also leaves the block, so the main counter can serve as a plain divider.

The words are meant for N from 3 to 1023 and A from 0 to 127. These are control pins: there is no stream traffic and no back-pressure, and `pre_pulse` is never held off.

Top module: `swallow_ctl`

## Requirements
- R1: While `rst_n` is low, `mod_hi` and `fv` are both 0.
- R2: On the first clock after reset release, both counters are preset from `n_word` and `a_word`. A `pre_pulse` in that clock is ignored, and the first cycle then follows R3 to R6 with those words.
- R3: Within a cycle, the first min(A, N) prescaler pulses are seen with `mod_hi` = 0, and the remaining pulses of the cycle are seen with `mod_hi` = 1. `mod_hi` = 1 selects divide-by-P and `mod_hi` = 0 selects divide-by-(P+1).
- R4: When A = 0, `mod_hi` is 1 from the first pulse of the cycle onward, so no pulse of the cycle sees it low.
- R5: A cycle consists of exactly N prescaler pulses. `fv` is 1 for exactly one clock, in the clock after the edge that takes the N-th pulse, and is never high on two consecutive clocks.
- R6: The spacing between consecutive `fv` pulses, counted in prescaler input periods, is N·P + A when A ≤ N and N·(P+1) when A > N.
- R7: A change of `n_word` or `a_word` in the middle of a cycle has no effect on that cycle. The new values are taken only at the next preset.
- R8: In a clock with no `pre_pulse`, the counters and `mod_hi` keep their values (after the initial preset).
- R9: `mod_hi` falls only at the end of a cycle, in the same clock as `fv` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_pulse | input | 1 | One-clock strobe per prescaler output period |
| n_word | input | NW (10) | Main count N |
| a_word | input | AW (7) | Swallow count A |
| mod_hi | output | 1 | Prescaler modulus select: 1 = divide by P, 0 = divide by P+1 |
| fv | output | 1 | One-clock pulse at the end of each cycle |

## Verification
Two functions can land on the same edge: the swallow counter reaching zero, and the terminal count of the main counter together with its preset. This happens when A equals N, and also when A exceeds N (the main count ends first). Directed pairs such as A = N = 127 and N = 3, A = 5 provoke it, alongside random words that are changed at random points mid-cycle. A behavioural prescaler that follows `mod_hi` judges every cycle in two ways. It counts the pulses seen with `mod_hi` low against min(A, N), and it measures the spacing between `fv` pulses against N·P + A or N·(P+1), using the words latched at the preceding preset.

// File: rtl/swallow_pkg.sv
package swallow_pkg;
  localparam int NW_DEF = 10;
  localparam int AW_DEF = 7;

  // Phase of a division cycle: swallow phase keeps prescaler at P+1
  typedef enum logic {
    PH_SWALLOW = 1'b0,
    PH_MAIN    = 1'b1
  } phase_e;
endpackage

// File: rtl/swallow_dn_ctr.sv
module swallow_dn_ctr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         is_zero,
  output logic         is_one
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= ld_val;
    else if (dec)  cnt <= cnt - ONE;
  end

  assign is_zero = (cnt == '0);
  assign is_one  = (cnt == ONE);
endmodule

// File: rtl/swallow_seq.sv
module swallow_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic pre_pulse,
  input  logic n_one,
  output logic loaded,
  output logic preset,
  output logic fv
);
  logic terminal;

  assign terminal = loaded & pre_pulse & n_one;
  assign preset   = ~loaded | terminal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded <= 1'b0;
      fv     <= 1'b0;
    end else begin
      loaded <= 1'b1;
      fv     <= terminal;
    end
  end
endmodule

// File: rtl/swallow_ctl.sv
module swallow_ctl #(
  parameter int NW = swallow_pkg::NW_DEF,
  parameter int AW = swallow_pkg::AW_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_pulse,
  input  logic [NW-1:0] n_word,
  input  logic [AW-1:0] a_word,
  output logic          mod_hi,
  output logic          fv
);
  import swallow_pkg::*;

  logic          loaded;
  logic          preset;
  logic          n_zero, n_one;
  logic          a_zero, a_one;
  logic [NW-1:0] n_cnt;
  logic [AW-1:0] a_cnt;
  logic          n_dec, a_dec;
  phase_e        phase;

  swallow_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pre_pulse (pre_pulse),
    .n_one     (n_one),
    .loaded    (loaded),
    .preset    (preset),
    .fv        (fv)
  );

  assign n_dec = loaded & pre_pulse;
  assign a_dec = loaded & pre_pulse & ~a_zero;

  swallow_dn_ctr #(.W(NW)) u_main (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (preset),
    .ld_val  (n_word),
    .dec     (n_dec),
    .cnt     (n_cnt),
    .is_zero (n_zero),
    .is_one  (n_one)
  );

  swallow_dn_ctr #(.W(AW)) u_swallow (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (preset),
    .ld_val  (a_word),
    .dec     (a_dec),
    .cnt     (a_cnt),
    .is_zero (a_zero),
    .is_one  (a_one)
  );

  assign phase  = (loaded && a_zero) ? PH_MAIN : PH_SWALLOW;
  assign mod_hi = (phase == PH_MAIN);
endmodule

// File: rtl/swallow_ctl_chk.sv
module swallow_ctl_chk #(
  parameter int NW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pre_pulse,
  input logic          mod_hi,
  input logic          fv,
  input logic          loaded,
  input logic [NW-1:0] n_cnt
);
  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (!mod_hi && !fv);
  end

  assert_fv_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fv |=> !fv);

  assert_fv_after_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fv |-> $past(pre_pulse));

  assert_mod_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_hi) |-> ($past(pre_pulse) || !$past(loaded)));

  assert_mod_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_hi) |-> fv);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && !pre_pulse) |=> ($stable(n_cnt) && $stable(mod_hi)));
endmodule

bind swallow_ctl swallow_ctl_chk #(.NW(NW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pre_pulse (pre_pulse),
  .mod_hi    (mod_hi),
  .fv        (fv),
  .loaded    (loaded),
  .n_cnt     (n_cnt)
);

// File: tb/test_swallow_ctl.sv
module test_swallow_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int P          = 4;
  localparam int WDOG       = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pre_pulse = 1'b0;
  logic [9:0] cur_n = 10'd10;
  logic [6:0] cur_a = 7'd3;
  logic       mod_hi, fv;

  always #(CLK_PERIOD/2) clk = ~clk;

  swallow_ctl i_swallow_ctl (
    .clk(clk), .rst_n(rst_n), .pre_pulse(pre_pulse),
    .n_word(cur_n), .a_word(cur_a), .mod_hi(mod_hi), .fv(fv)
  );

  int checks = 0, errors = 0;
  int cyc = 0, pcnt = 0, low_cnt = 0, fv_cnt = 0, last_fv = 0;
  bit have_prev = 0, first_cycle = 1, prev_mod = 0, prev_fv = 0;
  bit timeout = 0, rand_seg = 0;
  int eff_n = 10, eff_a = 3;

  function automatic int exp_div(int n, int a);
    return (a <= n) ? n * P + a : n * (P + 1);
  endfunction

  function automatic int exp_low(int n, int a);
    return (a < n) ? a : n;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc > WDOG) begin
      if (!timeout) check(0, "watchdog", cyc, WDOG);
      timeout = 1;
    end
    // R8: no pulse taken at the last edge -> modulus select unchanged
    if (cyc > 1 && !pre_pulse) check(mod_hi == prev_mod, "R8", mod_hi, prev_mod);
    // R9: falling modulus select only together with fv
    if (prev_mod && !mod_hi) check(fv, "R9", fv, 1);
    if (fv) begin
      check(!prev_fv, "R5", prev_fv, 0);
      if (first_cycle)
        check(low_cnt == exp_low(eff_n, eff_a), "R2", low_cnt, exp_low(eff_n, eff_a));
      else if (eff_a == 0)
        check(low_cnt == 0, "R4", low_cnt, 0);
      else
        check(low_cnt == exp_low(eff_n, eff_a), "R3", low_cnt, exp_low(eff_n, eff_a));
      if (have_prev) begin
        if (rand_seg)
          check(cyc - last_fv == exp_div(eff_n, eff_a), "R7", cyc - last_fv, exp_div(eff_n, eff_a));
        else
          check(cyc - last_fv == exp_div(eff_n, eff_a), "R6", cyc - last_fv, exp_div(eff_n, eff_a));
      end
      have_prev   = 1;
      first_cycle = 0;
      last_fv     = cyc;
      eff_n       = int'(cur_n);
      eff_a       = int'(cur_a);
      low_cnt     = 0;
      fv_cnt++;
    end
    prev_mod = mod_hi;
    prev_fv  = fv;
    // behavioural prescaler: ratio follows modulus select
    pcnt++;
    if (pcnt >= (mod_hi ? P : P + 1)) begin
      pre_pulse = 1'b1;
      pcnt = 0;
      if (!mod_hi) low_cnt++;
    end else begin
      pre_pulse = 1'b0;
    end
  endtask

  task automatic run_cycles(int k);
    int target;
    target = fv_cnt + k;
    while (fv_cnt < target && !timeout) step();
  endtask

  task automatic directed(int n, int a);
    cur_n = 10'(n);
    cur_a = 7'(a);
    run_cycles(3);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) begin
      @(negedge clk);
      check(!mod_hi && !fv, "R1", {mod_hi, fv}, 0);
    end
    rst_n = 1'b1;
    // first cycle after release uses the words present at release (R2)
    run_cycles(2);
    rand_seg = 0;
    directed(20, 0);     // R4
    directed(3, 0);
    directed(127, 127);  // swallow ends on the terminal pulse
    directed(3, 5);      // A > N
    directed(50, 49);
    directed(1023, 127);
    directed(3, 2);
    rand_seg = 1;
    for (int s = 0; s < 20 && !timeout; s++) begin
      int wait_n;
      // mid-cycle change, takes effect only at the next preset (R7)
      wait_n = int'($urandom_range(0, 150));
      for (int w = 0; w < wait_n && !timeout; w++) step();
      cur_n = 10'($urandom_range(3, 250));
      cur_a = 7'($urandom_range(0, 127));
      run_cycles(2);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule